// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

This block is one DMA channel that carries out a transfer made of several blocks. Software first programs a destination address, a first-descriptor pointer, a control word and a handshake configuration. It then sets the global enable and the channel enable. The channel reads a four-word descriptor over a dedicated read port. The descriptor reloads the channel's source address, control word and next pointer. The channel then moves the block one word at a time through a generic read/write master: each beat reads from the source address and writes that word to the destination address.

Only descriptors change the source address. The destination address is never taken from a descriptor; it keeps advancing from block to block, so the destination data forms one contiguous region. A block is split into transactions of 1, 2, 4 or 8 beats. Each transaction waits for a request from both the source side and the destination side. Each side gets its request either from a hardware request line or from a software request register bit. At the end of every transaction the channel acknowledges the requesting side.

When a block ends, the channel raises a block event and fetches the next descriptor at once, without waiting for software. A next pointer of zero ends the chain. At that point the channel raises a transfer-complete event and clears its own enable. An error response on either port stops the channel.

Top module: `ll_dma_chan`

## Requirements
- R1: After reset every register reads 0, irq is 0, and neither desc_req nor m_req is asserted.
- R2: Work starts only when bit 0 of the global enable register (index 0) and bit 0 of the channel enable register (index 1) are both 1. The first descriptor is then read from the pointer register (index 4). Its words are read at pointer+0x0, +0x4, +0x8 and +0xC, in that order, holding desc_addr steady until desc_ack.
- R3: A descriptor's words are, in order, source address, destination address, next pointer and control. The source, pointer and control registers (indexes 2, 4, 5) are reloaded from it. The destination word is discarded, and the destination register (index 3) keeps its value.
- R4: Each beat reads a word from the source address (m_we=0) and then writes that word to the destination address (m_we=1). m_req stays 0 while a descriptor read is in progress.
- R5: Control bits [1:0] set the source address step and bits [3:2] set the destination address step. Code 00 adds 4 after each beat, 01 subtracts 4, and 1x holds the address fixed.
- R6: Control bits [5:4] hold a code b, and a transaction is 2^b beats. Control bits [31:16] give the block length in beats, and the last transaction of a block may be shorter. A transaction starts only when both sides are requesting. Its end sets the source-transaction and destination-transaction raw bits and acknowledges both sides.
- R7: Configuration bit 0 (source) and bit 1 (destination) select the request source for each side. A value of 1 takes the request from software request register (index 7) bit 0 or bit 1, and that bit is cleared at the end of the transaction. A value of 0 takes the request from the hardware line selected by the index field: bits starting at 4 for the source and at 8 for the destination, each log2(NPER) bits wide. The ack on that line is a one-cycle pulse, and no other ack line is ever pulsed.
- R8: At the end of a block the block raw bit is set. If the pointer register is non-zero, the next descriptor is fetched from it at once, whether or not the block bit has been cleared.
- R9: If the pointer register is zero at the end of a block, the transfer-complete raw bit is set and the channel enable bit clears.
- R10: An error response (desc_err or m_err together with its ack) sets the error raw bit, clears the channel enable bit and stops all further requests.
- R11: The raw register (index 8) holds bit 0 transfer-complete, bit 1 block, bit 2 source-transaction, bit 3 destination-transaction and bit 4 error. The status register (index 9) reads raw AND mask, where the mask is register index 10. irq is the OR of status, one cycle later. Writing 1 to a bit of the clear register (index 11) clears that raw bit, and a new event in the same cycle takes priority over the clear.
- R12: While the channel is active, writes to the source, destination, pointer, control, configuration and channel enable registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index, for both write and read |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, one cycle after reg_addr |
| irq | output | 1 | OR of the masked interrupt status |
| desc_req | output | 1 | Descriptor read request |
| desc_addr | output | DW | Descriptor word address |
| desc_ack | input | 1 | Descriptor read response valid |
| desc_data | input | DW | Descriptor word |
| desc_err | input | 1 | Error response on a descriptor read |
| m_req | output | 1 | Data master request |
| m_we | output | 1 | Data master write (1) or read (0) |
| m_addr | output | DW | Data master address |
| m_wdata | output | DW | Data master write data |
| m_ack | input | 1 | Data master response |
| m_rdata | input | DW | Data master read data |
| m_err | input | 1 | Error response on the data master |
| src_hw_req | input | NPER | Hardware source request lines |
| dst_hw_req | input | NPER | Hardware destination request lines |
| src_hw_ack | output | NPER | Source transaction acknowledge pulses |
| dst_hw_ack | output | NPER | Destination transaction acknowledge pulses |

## Verification
The assertions check every cycle that the channel holds still while a port waits for its ack, and that start is gated by both enables. They also check that a descriptor load leaves the destination address untouched, that ack pulses stay one-hot, and that completion, errors and clears act on the enable and raw bits in the next cycle. Only the bench scenarios can show the end-to-end results. These include the exact address sequence through a three-descriptor chain with mixed step modes, and the destination address continuing across blocks. They also include the number of handshakes per transaction size, the locking of writes while the channel is active, and a transfer cut short by an error.

// File: rtl/ll_dma_pkg.sv
package ll_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAITREQ,
    ST_READ,
    ST_WRITE
  } seq_state_t;

  localparam logic [3:0] RG_GCFG  = 4'd0;
  localparam logic [3:0] RG_CHEN  = 4'd1;
  localparam logic [3:0] RG_SAR   = 4'd2;
  localparam logic [3:0] RG_DAR   = 4'd3;
  localparam logic [3:0] RG_LLP   = 4'd4;
  localparam logic [3:0] RG_CTRL  = 4'd5;
  localparam logic [3:0] RG_CFG   = 4'd6;
  localparam logic [3:0] RG_SWREQ = 4'd7;
  localparam logic [3:0] RG_RAW   = 4'd8;
  localparam logic [3:0] RG_STAT  = 4'd9;
  localparam logic [3:0] RG_MASK  = 4'd10;
  localparam logic [3:0] RG_CLR   = 4'd11;

  localparam int NEV    = 5;
  localparam int EV_TFR = 0;
  localparam int EV_BLK = 1;
  localparam int EV_SRC = 2;
  localparam int EV_DST = 3;
  localparam int EV_ERR = 4;
endpackage

// File: rtl/ll_dma_regs.sv
module ll_dma_regs
  import ll_dma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NPER  = 4,
  parameter int BLK_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_we,
  input  logic [3:0]          sw_addr,
  input  logic [DW-1:0]       sw_wdata,
  output logic [DW-1:0]       sw_rdata,
  output logic                irq,
  input  logic                busy,
  input  logic                ld_desc,
  input  logic [DW-1:0]       ld_sar,
  input  logic [DW-1:0]       ld_llp,
  input  logic [DW-1:0]       ld_ctrl,
  input  logic                adr_upd,
  input  logic [DW-1:0]       sar_nxt,
  input  logic [DW-1:0]       dar_nxt,
  input  logic                chen_clr,
  input  logic [1:0]          swreq_clr,
  input  logic [NEV-1:0]      ev,
  output logic                gen,
  output logic                chen,
  output logic [DW-1:0]       sar,
  output logic [DW-1:0]       dar,
  output logic [DW-1:0]       llp,
  output logic [1:0]          sinc,
  output logic [1:0]          dinc,
  output logic [1:0]          burst,
  output logic [BLK_W-1:0]    blk_size,
  output logic                hs_src,
  output logic                hs_dst,
  output logic [$clog2(NPER > 1 ? NPER : 2)-1:0] src_per,
  output logic [$clog2(NPER > 1 ? NPER : 2)-1:0] dst_per,
  output logic [1:0]          swreq
);
  localparam int PER_W = $clog2(NPER > 1 ? NPER : 2);

  logic [DW-1:0]  ctrl_q, cfg_q;
  logic [NEV-1:0] raw_q, mask_q, clr_bits;
  logic [1:0]     swreq_w;
  logic           cfg_wr_ok;

  assign cfg_wr_ok = sw_we && !busy;
  assign clr_bits  = (sw_we && sw_addr == RG_CLR) ? sw_wdata[NEV-1:0] : '0;
  assign swreq_w   = (sw_we && sw_addr == RG_SWREQ) ? sw_wdata[1:0] : swreq;

  assign sinc     = ctrl_q[1:0];
  assign dinc     = ctrl_q[3:2];
  assign burst    = ctrl_q[5:4];
  assign blk_size = ctrl_q[16 +: BLK_W];
  assign hs_src   = cfg_q[0];
  assign hs_dst   = cfg_q[1];
  assign src_per  = cfg_q[4 +: PER_W];
  assign dst_per  = cfg_q[8 +: PER_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      gen <= 1'b0; chen <= 1'b0;
      sar <= '0; dar <= '0; llp <= '0; ctrl_q <= '0; cfg_q <= '0;
      swreq <= '0; raw_q <= '0; mask_q <= '0; irq <= 1'b0; sw_rdata <= '0;
    end else begin
      if (sw_we && sw_addr == RG_GCFG) gen <= sw_wdata[0];
      if (chen_clr) chen <= 1'b0;
      else if (cfg_wr_ok && sw_addr == RG_CHEN) chen <= sw_wdata[0];

      if (ld_desc) sar <= ld_sar;
      else if (adr_upd) sar <= sar_nxt;
      else if (cfg_wr_ok && sw_addr == RG_SAR) sar <= sw_wdata;

      if (adr_upd) dar <= dar_nxt;
      else if (cfg_wr_ok && sw_addr == RG_DAR) dar <= sw_wdata;

      if (ld_desc) llp <= ld_llp;
      else if (cfg_wr_ok && sw_addr == RG_LLP) llp <= sw_wdata;

      if (ld_desc) ctrl_q <= ld_ctrl;
      else if (cfg_wr_ok && sw_addr == RG_CTRL) ctrl_q <= sw_wdata;

      if (cfg_wr_ok && sw_addr == RG_CFG) cfg_q <= sw_wdata;
      if (sw_we && sw_addr == RG_MASK) mask_q <= sw_wdata[NEV-1:0];

      swreq <= swreq_w & ~swreq_clr;
      raw_q <= (raw_q & ~clr_bits) | ev;
      irq   <= |(raw_q & mask_q);

      case (sw_addr)
        RG_GCFG:  sw_rdata <= DW'(gen);
        RG_CHEN:  sw_rdata <= DW'(chen);
        RG_SAR:   sw_rdata <= sar;
        RG_DAR:   sw_rdata <= dar;
        RG_LLP:   sw_rdata <= llp;
        RG_CTRL:  sw_rdata <= ctrl_q;
        RG_CFG:   sw_rdata <= cfg_q;
        RG_SWREQ: sw_rdata <= DW'(swreq);
        RG_RAW:   sw_rdata <= DW'(raw_q);
        RG_STAT:  sw_rdata <= DW'(raw_q & mask_q);
        RG_MASK:  sw_rdata <= DW'(mask_q);
        default:  sw_rdata <= '0;
      endcase
    end
  end

  AST_DAR_KEPT: assert property (@(posedge clk) disable iff (rst)
    ld_desc |=> dar == $past(dar)); // R3
  AST_TFR_STOPS: assert property (@(posedge clk) disable iff (rst)
    ev[EV_TFR] |=> !chen && raw_q[EV_TFR]); // R9
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
    ev[EV_ERR] |=> !chen && raw_q[EV_ERR]); // R10
  AST_CLEAR_BLK: assert property (@(posedge clk) disable iff (rst)
    (clr_bits[EV_BLK] && !ev[EV_BLK]) |=> !raw_q[EV_BLK]); // R11
  AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (rst)
    (busy && !ld_desc) |=> ctrl_q == $past(ctrl_q)); // R12
endmodule

// File: rtl/ll_dma_seq.sv
module ll_dma_seq
  import ll_dma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NPER  = 4,
  parameter int BLK_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gen,
  input  logic                chen,
  input  logic [DW-1:0]       sar,
  input  logic [DW-1:0]       dar,
  input  logic [DW-1:0]       llp,
  input  logic [1:0]          sinc,
  input  logic [1:0]          dinc,
  input  logic [1:0]          burst,
  input  logic                hs_src,
  input  logic                hs_dst,
  input  logic [$clog2(NPER > 1 ? NPER : 2)-1:0] src_per,
  input  logic [$clog2(NPER > 1 ? NPER : 2)-1:0] dst_per,
  input  logic [1:0]          swreq,
  output logic                desc_req,
  output logic [DW-1:0]       desc_addr,
  input  logic                desc_ack,
  input  logic [DW-1:0]       desc_data,
  input  logic                desc_err,
  output logic                m_req,
  output logic                m_we,
  output logic [DW-1:0]       m_addr,
  output logic [DW-1:0]       m_wdata,
  input  logic                m_ack,
  input  logic [DW-1:0]       m_rdata,
  input  logic                m_err,
  input  logic [NPER-1:0]     src_hw_req,
  input  logic [NPER-1:0]     dst_hw_req,
  output logic [NPER-1:0]     src_hw_ack,
  output logic [NPER-1:0]     dst_hw_ack,
  output logic                busy,
  output logic                ld_desc,
  output logic [DW-1:0]       ld_sar,
  output logic [DW-1:0]       ld_llp,
  output logic [DW-1:0]       ld_ctrl,
  output logic                adr_upd,
  output logic [DW-1:0]       sar_nxt,
  output logic [DW-1:0]       dar_nxt,
  output logic                chen_clr,
  output logic [1:0]          swreq_clr,
  output logic [NEV-1:0]      ev
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);
  localparam int BC_W = 4;

  function automatic logic [DW-1:0] step_addr(input logic [DW-1:0] a, input logic [1:0] mode);
    case (mode)
      2'b00:   return a + STEP;
      2'b01:   return a - STEP;
      default: return a;
    endcase
  endfunction

  seq_state_t      st;
  logic [1:0]      widx;
  logic [DW-1:0]   cap_sar, cap_llp, dbuf;
  logic [BLK_W-1:0] remain;
  logic [BC_W-1:0] beat, burst_len;
  logic src_ok, dst_ok, desc_ok, m_ok, beat_done, tran_end, blk_end, fault, last;

  assign burst_len = BC_W'(1) << burst;
  assign src_ok    = hs_src ? swreq[0] : src_hw_req[src_per];
  assign dst_ok    = hs_dst ? swreq[1] : dst_hw_req[dst_per];

  assign desc_ok   = (st == ST_FETCH) && desc_ack;
  assign m_ok      = (st == ST_READ || st == ST_WRITE) && m_ack;
  assign beat_done = (st == ST_WRITE) && m_ack && !m_err;
  assign tran_end  = beat_done && ((beat + BC_W'(1) == burst_len) || remain == BLK_W'(1));
  assign blk_end   = (tran_end && remain == BLK_W'(1)) || (st == ST_WAITREQ && remain == '0);
  assign fault     = (desc_ok && desc_err) || (m_ok && m_err);
  assign last      = blk_end && (llp == '0);

  assign busy      = (st != ST_IDLE);
  assign desc_req  = (st == ST_FETCH);
  assign desc_addr = llp + DW'({widx, 2'b00});
  assign m_req     = (st == ST_READ) || (st == ST_WRITE);
  assign m_we      = (st == ST_WRITE);
  assign m_addr    = (st == ST_WRITE) ? dar : sar;
  assign m_wdata   = dbuf;

  assign ld_desc   = desc_ok && !desc_err && (widx == 2'd3);
  assign ld_sar    = cap_sar;
  assign ld_llp    = cap_llp;
  assign ld_ctrl   = desc_data;
  assign adr_upd   = beat_done;
  assign sar_nxt   = step_addr(sar, sinc);
  assign dar_nxt   = step_addr(dar, dinc);
  assign chen_clr  = last || fault;
  assign swreq_clr = tran_end ? {hs_dst, hs_src} : 2'b00;

  always_comb begin
    ev         = '0;
    ev[EV_TFR] = last;
    ev[EV_BLK] = blk_end;
    ev[EV_SRC] = tran_end;
    ev[EV_DST] = tran_end;
    ev[EV_ERR] = fault;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; widx <= '0; cap_sar <= '0; cap_llp <= '0; dbuf <= '0;
      remain <= '0; beat <= '0; src_hw_ack <= '0; dst_hw_ack <= '0;
    end else begin
      src_hw_ack <= '0;
      dst_hw_ack <= '0;
      if (tran_end && !hs_src) src_hw_ack[src_per] <= 1'b1;
      if (tran_end && !hs_dst) dst_hw_ack[dst_per] <= 1'b1;
      case (st)
        ST_IDLE: if (gen && chen) begin
          st <= ST_FETCH; widx <= '0;
        end
        ST_FETCH: if (desc_ack) begin
          if (desc_err) st <= ST_IDLE;
          else begin
            if (widx == 2'd0) cap_sar <= desc_data;
            if (widx == 2'd2) cap_llp <= desc_data;
            widx <= widx + 2'd1;
            if (widx == 2'd3) begin
              st <= ST_WAITREQ;
              remain <= desc_data[16 +: BLK_W];
              beat <= '0;
            end
          end
        end
        ST_WAITREQ: begin
          beat <= '0;
          if (remain == '0) begin
            st <= (llp == '0) ? ST_IDLE : ST_FETCH;
            widx <= '0;
          end else if (src_ok && dst_ok) st <= ST_READ;
        end
        ST_READ: if (m_ack) begin
          if (m_err) st <= ST_IDLE;
          else begin
            dbuf <= m_rdata;
            st <= ST_WRITE;
          end
        end
        ST_WRITE: if (m_ack) begin
          if (m_err) st <= ST_IDLE;
          else begin
            remain <= remain - BLK_W'(1);
            beat <= beat + BC_W'(1);
            if (tran_end) begin
              beat <= '0;
              if (remain == BLK_W'(1)) begin
                st <= (llp == '0) ? ST_IDLE : ST_FETCH;
                widx <= '0;
              end else st <= ST_WAITREQ;
            end else st <= ST_READ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(gen && chen)) |=> !desc_req); // R2
  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (desc_req && !desc_ack) |=> desc_req && $stable(desc_addr)); // R2
  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack) |=> m_req && $stable(m_addr) && $stable(m_we)); // R4
  AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_we && m_ack && !m_err) |=> !(m_req && m_we)); // R4
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_hw_ack) && $onehot0(dst_hw_ack)); // R7
  AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (rst)
    fault |=> !desc_req && !m_req); // R10
endmodule

// File: rtl/ll_dma_chan.sv
module ll_dma_chan
  import ll_dma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NPER  = 4,
  parameter int BLK_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [3:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq,
  output logic            desc_req,
  output logic [DW-1:0]   desc_addr,
  input  logic            desc_ack,
  input  logic [DW-1:0]   desc_data,
  input  logic            desc_err,
  output logic            m_req,
  output logic            m_we,
  output logic [DW-1:0]   m_addr,
  output logic [DW-1:0]   m_wdata,
  input  logic            m_ack,
  input  logic [DW-1:0]   m_rdata,
  input  logic            m_err,
  input  logic [NPER-1:0] src_hw_req,
  input  logic [NPER-1:0] dst_hw_req,
  output logic [NPER-1:0] src_hw_ack,
  output logic [NPER-1:0] dst_hw_ack
);
  localparam int PER_W = $clog2(NPER > 1 ? NPER : 2);

  logic             busy, ld_desc, adr_upd, chen_clr, gen, chen, hs_src, hs_dst;
  logic [DW-1:0]    ld_sar, ld_llp, ld_ctrl, sar_nxt, dar_nxt, sar, dar, llp;
  logic [1:0]       swreq_clr, swreq, sinc, dinc, burst;
  logic [NEV-1:0]   ev;
  logic [BLK_W-1:0] blk_size;
  logic [PER_W-1:0] src_per, dst_per;

  ll_dma_regs #(.DW(DW), .NPER(NPER), .BLK_W(BLK_W)) u_regs (
    .clk, .rst,
    .sw_we(reg_we), .sw_addr(reg_addr), .sw_wdata(reg_wdata), .sw_rdata(reg_rdata),
    .irq, .busy, .ld_desc, .ld_sar, .ld_llp, .ld_ctrl,
    .adr_upd, .sar_nxt, .dar_nxt, .chen_clr, .swreq_clr, .ev,
    .gen, .chen, .sar, .dar, .llp, .sinc, .dinc, .burst, .blk_size,
    .hs_src, .hs_dst, .src_per, .dst_per, .swreq
  );

  ll_dma_seq #(.DW(DW), .NPER(NPER), .BLK_W(BLK_W)) u_seq (
    .clk, .rst, .gen, .chen, .sar, .dar, .llp, .sinc, .dinc, .burst,
    .hs_src, .hs_dst, .src_per, .dst_per, .swreq,
    .desc_req, .desc_addr, .desc_ack, .desc_data, .desc_err,
    .m_req, .m_we, .m_addr, .m_wdata, .m_ack, .m_rdata, .m_err,
    .src_hw_req, .dst_hw_req, .src_hw_ack, .dst_hw_ack,
    .busy, .ld_desc, .ld_sar, .ld_llp, .ld_ctrl,
    .adr_upd, .sar_nxt, .dar_nxt, .chen_clr, .swreq_clr, .ev
  );

  AST_BLK_SIZE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && !ld_desc) |=> blk_size == $past(blk_size)); // R12
endmodule

// File: tb/ll_dma_chan_bench.sv
`timescale 1ns/1ps
module ll_dma_chan_bench;
  localparam int DW = 32;
  localparam int NPER = 4;
  localparam int BLK_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq, desc_req, m_req, m_we;
  logic [DW-1:0] desc_addr, m_addr, m_wdata;
  logic desc_ack = 1'b0, desc_err = 1'b0, m_ack = 1'b0, m_err = 1'b0;
  logic [DW-1:0] desc_data = '0, m_rdata = '0;
  logic [NPER-1:0] src_hw_req = '0, dst_hw_req = '0;
  logic [NPER-1:0] src_hw_ack, dst_hw_ack;

  always #2.5 clk = ~clk;

  ll_dma_chan #(.DW(DW), .NPER(NPER), .BLK_W(BLK_W)) u_ll_dma_chan (
    .clk, .rst, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq,
    .desc_req, .desc_addr, .desc_ack, .desc_data, .desc_err,
    .m_req, .m_we, .m_addr, .m_wdata, .m_ack, .m_rdata, .m_err,
    .src_hw_req, .dst_hw_req, .src_hw_ack, .dst_hw_ack
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int desc_cycles = 0, src_acks = 0, dst_acks = 0;
  int s_gap = 0, d_gap = 0;
  bit hw_mode = 0, done_flag = 0;
  logic [DW-1:0] err_addr = 32'hFFFF_FFF0;
  logic [31:0] mem [0:1023];
  logic [31:0] q_desc[$], q_rd[$], q_wr[$], q_wd[$];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  function automatic logic [31:0] stepm(input logic [31:0] a, input logic [1:0] m);
    if (m == 2'b00) return a + 4;
    if (m == 2'b01) return a - 4;
    return a;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic add_desc(input logic [31:0] base, input logic [31:0] s,
                          input logic [31:0] nxt, input logic [31:0] c);
    mem[base[11:2]]       = s;
    mem[base[11:2] + 1]   = 32'hDEAD_BEE0;
    mem[base[11:2] + 2]   = nxt;
    mem[base[11:2] + 3]   = c;
    for (int k = 0; k < 4; k++) q_desc.push_back(base + 4 * k);
  endtask

  task automatic add_beats(input logic [31:0] s0, inout logic [31:0] d, input logic [31:0] c);
    logic [31:0] s;
    s = s0;
    for (int k = 0; k < int'(c[31:16]); k++) begin
      q_rd.push_back(s);
      q_wr.push_back(d);
      q_wd.push_back(pat(s));
      s = stepm(s, c[1:0]);
      d = stepm(d, c[3:2]);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int k = 0; k < 2000; k++) begin
      rd(4'd1, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  // per-cycle model of the memory, descriptor port and peripherals
  initial begin
    for (int k = 0; k < 1024; k++) mem[k] = pat(32'(k * 4));
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 60000 && !done_flag) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<60000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
      if (desc_req) begin
        desc_cycles++;
        check("R4 master idle during fetch", 32'(m_req), 32'd0);
      end
      for (int i = 0; i < NPER; i++) begin
        if (src_hw_ack[i] && (!hw_mode || i != 2)) check("R7 stray src ack", 32'(i), 32'd2);
        if (dst_hw_ack[i] && (!hw_mode || i != 1)) check("R7 stray dst ack", 32'(i), 32'd1);
      end
      // descriptor port
      if (desc_ack) desc_ack = 1'b0;
      else if (desc_req) begin
        if (q_desc.size() == 0) check("R2 unexpected fetch", desc_addr, 32'hFFFF_FFFF);
        else check("R2 desc addr", desc_addr, q_desc.pop_front());
        desc_data = mem[desc_addr[11:2]];
        desc_ack = 1'b1;
      end
      // data master
      if (m_ack) begin m_ack = 1'b0; m_err = 1'b0; end
      else if (m_req) begin
        if (!m_we) begin
          if (q_rd.size() == 0) check("R4 unexpected read", m_addr, 32'hFFFF_FFFF);
          else check("R5 read addr", m_addr, q_rd.pop_front());
          m_rdata = mem[m_addr[11:2]];
          m_err = (m_addr == err_addr);
        end else begin
          if (q_wr.size() == 0) check("R4 unexpected write", m_addr, 32'hFFFF_FFFF);
          else begin
            check("R5 write addr", m_addr, q_wr.pop_front());
            check("R4 write data", m_wdata, q_wd.pop_front());
          end
          mem[m_addr[11:2]] = m_wdata;
        end
        m_ack = 1'b1;
      end
      // hardware peripherals on source line 2, destination line 1
      if (src_hw_ack[2]) begin src_acks++; s_gap = 2; end
      if (dst_hw_ack[1]) begin dst_acks++; d_gap = 2; end
      if (s_gap > 0) s_gap--;
      if (d_gap > 0) d_gap--;
      src_hw_req = (hw_mode && s_gap == 0) ? 4'b0100 : 4'b0000;
      dst_hw_req = (hw_mode && d_gap == 0) ? 4'b0010 : 4'b0000;
    end
  end

  initial begin
    logic [31:0] v, d;
    logic [31:0] c0, c1, c2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 desc_req", 32'(desc_req), 32'd0);
    check("R1 m_req", 32'(m_req), 32'd0);
    rd(4'd1, v); check("R1 chen", v, 32'd0);
    rd(4'd8, v); check("R1 raw", v, 32'd0);
    rd(4'd2, v); check("R1 sar", v, 32'd0);

    // Scenario A: three chained blocks, hardware handshake
    c0 = 32'h0003_0010;  // 3 beats, 2-beat transactions, inc/inc
    c1 = 32'h0002_0001;  // 2 beats, single, source decrement
    c2 = 32'h0002_0012;  // 2 beats, 2-beat transaction, source fixed
    d = 32'h800;
    add_desc(32'h100, 32'h400, 32'h120, c0); add_beats(32'h400, d, c0);
    add_desc(32'h120, 32'h500, 32'h140, c1); add_beats(32'h500, d, c1);
    add_desc(32'h140, 32'h600, 32'h0,   c2); add_beats(32'h600, d, c2);
    wr(4'd3, 32'h800);
    wr(4'd4, 32'h100);
    wr(4'd5, c0);
    wr(4'd6, 32'h0000_0120);
    wr(4'd10, 32'h2);
    hw_mode = 1;
    wr(4'd1, 32'h1);
    desc_cycles = 0;
    repeat (20) @(negedge clk);
    check("R2 no start without global enable", 32'(desc_cycles), 32'd0);
    wr(4'd0, 32'h1);
    wait_done();
    check("R8 all descriptors fetched", 32'(q_desc.size()), 32'd0);
    check("R4 all beats done", 32'(q_wr.size()), 32'd0);
    check("R6 source acks", 32'(src_acks), 32'd5);
    check("R6 dest acks", 32'(dst_acks), 32'd5);
    rd(4'd3, v); check("R3 dar contiguous", v, 32'h81C);
    rd(4'd2, v); check("R3 sar reloaded", v, 32'h600);
    rd(4'd4, v); check("R3 llp reloaded", v, 32'h0);
    rd(4'd5, v); check("R3 ctrl reloaded", v, c2);
    rd(4'd1, v); check("R9 chen cleared", v, 32'd0);
    rd(4'd8, v); check("R9 raw after chain", v, 32'hF);
    rd(4'd9, v); check("R11 status masked", v, 32'h2);
    check("R11 irq set", 32'(irq), 32'd1);
    wr(4'd11, 32'h1F);
    @(negedge clk);
    check("R11 irq after clear", 32'(irq), 32'd0);
    rd(4'd8, v); check("R11 raw cleared", v, 32'd0);
    hw_mode = 0;

    // Scenario B: software handshake, locked registers
    add_desc(32'h180, 32'h700, 32'h0, 32'h0001_0000);
    q_rd.push_back(32'h700); q_wr.push_back(32'h900); q_wd.push_back(pat(32'h700));
    wr(4'd3, 32'h900);
    wr(4'd4, 32'h180);
    wr(4'd6, 32'h3);
    wr(4'd1, 32'h1);
    repeat (12) @(negedge clk);
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd3, 32'h123);
    rd(4'd3, v); check("R12 dar write ignored", v, 32'h900);
    wr(4'd7, 32'h3);
    wait_done();
    rd(4'd3, v); check("R5 dar stepped", v, 32'h904);
    rd(4'd5, v); check("R12 ctrl write ignored", v, 32'h0001_0000);
    rd(4'd7, v); check("R7 sw request cleared", v, 32'd0);
    rd(4'd8, v); check("R6 raw after sw block", v, 32'hF);
    wr(4'd11, 32'h1F);

    // Scenario C: data read error mid-transaction
    add_desc(32'h1C0, 32'h740, 32'h0, 32'h0004_0020);
    q_rd.push_back(32'h740); q_rd.push_back(32'h744);
    q_wr.push_back(32'h980); q_wd.push_back(pat(32'h740));
    err_addr = 32'h744;
    wr(4'd3, 32'h980);
    wr(4'd4, 32'h1C0);
    wr(4'd1, 32'h1);
    wr(4'd7, 32'h3);
    wait_done();
    repeat (10) @(negedge clk);
    rd(4'd8, v); check("R10 raw error only", v, 32'h10);
    rd(4'd1, v); check("R10 chen cleared", v, 32'd0);
    rd(4'd3, v); check("R10 dar after one beat", v, 32'h984);
    check("R10 no further reads", 32'(q_rd.size()), 32'd0);
    check("R10 requests stopped", 32'(m_req | desc_req), 32'd0);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule